// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This bridge places the registers of a legacy ATA task-file port inside a 4 KB window of a processor memory bus. Each register occupies its own 16-byte slot, so the slot number is taken from address bits [11:4]. Byte-wide accesses reach the seven task-file registers and the device control / alternate status register. Two slots alias the latter. Half-word and word accesses reach only the data port, in slot 0. A parameter selects a byte-lane reversal so that a big-endian host sees the data port in its native order.

The bridge also drives the host interrupt line. A one-cycle event from the device sets a pending flag. The line shows that flag unless the interrupt-disable bit of the device control register is set. The bridge keeps its own copy of that register. A byte read of the main status slot clears the flag. A read of the alternate status leaves it alone.

The bus side takes a single-cycle request. Read data is returned one cycle later together with a valid strobe. The device side sees a register index, a width code and exactly one read or write strobe for every access it accepts.

Top module: `ata_mmio_bridge`

## Requirements
- R1: The slot index is bus address bits [11:4]. All other address bits have no effect on decoding.
- R2: A byte write to slot 1 to 7 gives one device write strobe with device index equal to the slot, width code 0, and the data byte in dev_wdata[7:0].
- R3: A byte write to slot 8 or slot 22 gives one device write strobe at device index 8. The byte is also copied into the internal control mirror.
- R4: A byte read of slot 1 to 7 gives one device read strobe. In the next cycle bus_rvalid is high and bus_rdata is {24'h0, device byte}.
- R5: A byte read of slot 8 or 22 gives one device read strobe at device index 8 and returns the alternate status. It leaves irq_out unchanged.
- R6: A byte access to any other slot, including slot 0, makes no device strobe. A read of such a slot returns 32'h0000_00FF.
- R7: A half-word access (size code 1) or word access (size code 2) to slot 0 gives exactly one device strobe at device index 0 with the same width code. The same access to any other slot makes no strobe, and a read returns 32'h0000_FFFF for a half-word or 32'hFFFF_FFFF for a word.
- R8: With BIG_ENDIAN set, data-port data is byte-reversed at the access width in both directions. A half-word swaps bits [15:8] and [7:0] (upper half zero). A word reverses all four bytes.
- R9: irq_out is high exactly when the pending flag is set and bit 1 (interrupt disable) of the control mirror is clear.
- R10: A device interrupt event sets the pending flag. A byte read of slot 7 clears it, with irq_out low in the next cycle. If an event and that read fall in the same cycle, the event wins and the flag stays set.
- R11: After reset the pending flag, the control mirror and bus_rvalid are zero.
- R12: Size code 3 is never accepted. It makes no device strobe, and a read returns 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Size code: 0 byte, 1 half-word, 2 word |
| bus_we | input | 1 | High for a write |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data, right-aligned |
| dev_idx | output | 4 | Device register: 0 data, 1..7 task file, 8 control/alt status |
| dev_size | output | 2 | Device transfer width code |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 32 | Data to device |
| dev_rdata | input | 32 | Data from device, valid while dev_rd is high |
| dev_intrq | input | 1 | One-cycle interrupt event from device |
| irq_out | output | 1 | Interrupt line to the host controller |

## Verification
Two interrupt functions can meet in one cycle: a device interrupt event can arrive in the same cycle as a host read of the main status slot. The bench drives both in one request cycle. It then requires irq_out to stay high, because the new event must not be lost. A separate status read afterwards must clear the line. The bench also checks that a write which sets the disable bit masks a flag that is already pending, and that clearing the bit shows the flag again.

// File: rtl/ata_mmio_bridge.sv
module ata_mmio_bridge #(
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        dev_idx,
  output logic [1:0]        dev_size,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata,
  input  logic              dev_intrq,
  output logic              irq_out
);
  localparam int SLOT_LSB = 4;
  localparam int SLOT_W   = 8;
  localparam int NIEN_BIT = 1;

  logic [SLOT_W-1:0] slot;
  logic sz_byte, sz_wide, in_tf, in_ctl, in_dat;
  logic hit_tf, hit_ctl, hit_dat, hit;
  logic [7:0] ctl_q;
  logic pend_q;

  function automatic logic [31:0] lane_fix(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd1)
      lane_fix = BIG_ENDIAN ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
    else
      lane_fix = BIG_ENDIAN ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  assign slot    = bus_addr[SLOT_LSB +: SLOT_W];
  assign sz_byte = bus_size == 2'd0;
  assign sz_wide = bus_size == 2'd1 || bus_size == 2'd2;
  assign in_tf   = slot >= 8'd1 && slot <= 8'd7;
  assign in_ctl  = slot == 8'd8 || slot == 8'd22;
  assign in_dat  = slot == 8'd0;

  assign hit_tf  = bus_req && sz_byte && in_tf;
  assign hit_ctl = bus_req && sz_byte && in_ctl;
  assign hit_dat = bus_req && sz_wide && in_dat;
  assign hit     = hit_tf || hit_ctl || hit_dat;

  assign dev_wr    = hit && bus_we;
  assign dev_rd    = hit && !bus_we;
  assign dev_size  = bus_size;
  assign dev_idx   = hit_ctl ? 4'd8 : hit_dat ? 4'd0 : slot[3:0];
  assign dev_wdata = hit_dat ? lane_fix(bus_wdata, bus_size) : {24'h0, bus_wdata[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        if (hit_dat)       bus_rdata <= lane_fix(dev_rdata, bus_size);
        else if (hit)      bus_rdata <= {24'h0, dev_rdata[7:0]};
        else if (sz_byte)  bus_rdata <= 32'h0000_00FF;
        else if (bus_size == 2'd1) bus_rdata <= 32'h0000_FFFF;
        else               bus_rdata <= 32'hFFFF_FFFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hit_ctl && bus_we) ctl_q <= bus_wdata[7:0];
      if (dev_intrq) pend_q <= 1'b1;
      else if (hit_tf && !bus_we && slot == 8'd7) pend_q <= 1'b0;
    end
  end

  assign irq_out = pend_q && !ctl_q[NIEN_BIT];

  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |=> bus_rvalid);

  // R6
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !dev_rd && !dev_wr);

  // R9
  nien_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr && dev_idx == 4'd8 && bus_wdata[NIEN_BIT] |=> !irq_out);

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd && dev_idx == 4'd7 && dev_size == 2'd0 && !dev_intrq |=> !irq_out);

  // R10
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_intrq && !(dev_wr && dev_idx == 4'd8) && !ctl_q[NIEN_BIT] |=> irq_out);

  // R12
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_size == 2'd3 |-> !dev_rd && !dev_wr);
endmodule

// File: tb/tb_ata_mmio_bridge.sv
module tb_ata_mmio_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0, dev_intrq = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, dev_rdata;
  logic [1:0] bus_size = '0;
  logic bus_rvalid, dev_rd, dev_wr, irq_out;
  logic [31:0] bus_rdata, dev_wdata;
  logic [3:0] dev_idx;
  logic [1:0] dev_size;

  int checks = 0, fails = 0, nstb = 0;
  logic [3:0] l_idx; logic [1:0] l_size; logic [31:0] l_wdata; logic l_wr;
  logic [7:0] tf [0:8];
  logic [31:0] dreg;
  localparam logic [7:0] ALT = 8'h5A;

  always #5 clk = ~clk;

  ata_mmio_bridge #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) dut (.*);

  always_comb begin
    if (dev_idx == 4'd0)      dev_rdata = dreg;
    else if (dev_idx == 4'd8) dev_rdata = {24'h0, ALT};
    else                      dev_rdata = {24'hEEEEEE, tf[dev_idx]};
  end

  always @(posedge clk) begin
    if (dev_rd || dev_wr) begin
      nstb <= nstb + 1;
      l_idx <= dev_idx; l_size <= dev_size; l_wdata <= dev_wdata; l_wr <= dev_wr;
      if (dev_wr && dev_idx == 4'd0) dreg <= dev_wdata;
      else if (dev_wr) tf[dev_idx] <= dev_wdata[7:0];
    end
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sz, input logic we, input logic [31:0] a,
                     input logic [31:0] wd, input logic intr = 1'b0);
    @(negedge clk);
    bus_req = 1'b1; bus_size = sz; bus_we = we; bus_addr = a; bus_wdata = wd; dev_intrq = intr;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; dev_intrq = 1'b0;
  endtask

  task automatic pulse_intr();
    @(negedge clk); dev_intrq = 1'b1;
    @(negedge clk); dev_intrq = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rvalid", bus_rvalid, 0);
    chk("R11 irq", irq_out, 0);
    pulse_intr();
    chk("R11 mirror zero so irq shows", irq_out, 1);
    acc(2'd0, 1'b0, 32'h70, 0);
    chk("R10 status read clears", irq_out, 0);
  endtask

  task automatic t_tf_write();
    int n0;
    n0 = nstb;
    acc(2'd0, 1'b1, 32'hABC0_0035, 32'h1234_56C3);
    chk("R1 one strobe", nstb - n0, 1);
    chk("R1 idx from [11:4]", l_idx, 3);
    chk("R2 write flag", l_wr, 1);
    chk("R2 width", l_size, 0);
    chk("R2 data byte", l_wdata, 32'h0000_00C3);
    acc(2'd0, 1'b1, 32'h7F, 32'h99);
    chk("R2 slot 7 stored", tf[7], 8'h99);
  endtask

  task automatic t_tf_read();
    acc(2'd0, 1'b0, 32'h0000_1030, 0);
    chk("R4 rvalid", bus_rvalid, 1);
    chk("R4 rdata", bus_rdata, 32'h0000_00C3);
    @(negedge clk);
    chk("R4 rvalid drops", bus_rvalid, 0);
  endtask

  task automatic t_ctl();
    int n0;
    n0 = nstb;
    acc(2'd0, 1'b1, 32'h80, 32'h00);
    chk("R3 slot 8 idx", l_idx, 8);
    acc(2'd0, 1'b1, 32'h160, 32'h00);
    chk("R3 slot 22 idx", l_idx, 8);
    chk("R3 two strobes", nstb - n0, 2);
    pulse_intr();
    chk("R9 irq shown", irq_out, 1);
    acc(2'd0, 1'b0, 32'h160, 0);
    chk("R5 alt data", bus_rdata, {24'h0, ALT});
    chk("R5 alt idx", l_idx, 8);
    chk("R5 irq kept", irq_out, 1);
    acc(2'd0, 1'b1, 32'h160, 32'h02);
    chk("R3 R9 disable masks", irq_out, 0);
    acc(2'd0, 1'b1, 32'h80, 32'h00);
    chk("R9 unmask shows pending", irq_out, 1);
    acc(2'd0, 1'b0, 32'h70, 0, 1'b1);
    chk("R10 event wins same cycle", irq_out, 1);
    acc(2'd0, 1'b0, 32'h70, 0);
    chk("R10 later read clears", irq_out, 0);
  endtask

  task automatic t_unmapped();
    int n0;
    n0 = nstb;
    acc(2'd0, 1'b0, 32'h00, 0);
    chk("R6 slot0 byte read", bus_rdata, 32'h0000_00FF);
    acc(2'd0, 1'b0, 32'h90, 0);
    chk("R6 slot9 byte read", bus_rdata, 32'h0000_00FF);
    acc(2'd0, 1'b1, 32'hF00, 32'h11);
    chk("R6 no strobes", nstb - n0, 0);
    acc(2'd1, 1'b0, 32'h10, 0);
    chk("R7 half off-port", bus_rdata, 32'h0000_FFFF);
    acc(2'd2, 1'b0, 32'h20, 0);
    chk("R7 word off-port", bus_rdata, 32'hFFFF_FFFF);
    acc(2'd2, 1'b1, 32'h30, 32'h0);
    chk("R7 no strobes off-port", nstb - n0, 0);
    chk("R7 tf3 untouched", tf[3], 8'hC3);
    acc(2'd3, 1'b0, 32'h00, 0);
    chk("R12 size3 read", bus_rdata, 32'hFFFF_FFFF);
    acc(2'd3, 1'b1, 32'h00, 32'h5);
    chk("R12 no strobes", nstb - n0, 0);
  endtask

  task automatic t_data();
    int n0;
    n0 = nstb;
    acc(2'd2, 1'b1, 32'h5000_0008, 32'h1122_3344);
    chk("R7 one word strobe", nstb - n0, 1);
    chk("R7 word width", l_size, 2);
    chk("R8 word write swap", l_wdata, 32'h4433_2211);
    acc(2'd2, 1'b0, 32'h0, 0);
    chk("R8 word read swap", bus_rdata, 32'h1122_3344);
    acc(2'd1, 1'b1, 32'h0, 32'h0000_A1B2);
    chk("R7 half width", l_size, 1);
    chk("R8 half write swap", l_wdata, 32'h0000_B2A1);
    @(negedge clk); dreg = 32'hDEAD_C0DE;
    acc(2'd1, 1'b0, 32'h4, 0);
    chk("R8 half read swap", bus_rdata, 32'h0000_DEC0);
    chk("R7 strobe count", nstb - n0, 4);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) tf[i] = 8'h00;
    dreg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tf_write();
    t_tf_read();
    t_ctl();
    t_unmapped();
    t_data();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule